// File: doc/BRIEF.md
# Dual-Width Integer ALU Execute Stage

This block is the integer execute stage of a 64-bit register machine. Each cycle it may accept one instruction, given as an 8-bit opcode plus three operands: the current destination register value, the source register value and a 32-bit immediate. One clock later it returns the new destination value with a write enable, or it raises an illegal-instruction flag.

Two instruction classes share a single table of operation codes. The narrow class computes on the low 32 bits and clears the upper half of the result. The wide class computes on full 64-bit operands and sign-extends the immediate to 64 bits first. Division and remainder with a zero divisor never trap. A zero divisor gives a result of zero for division. For remainder it gives back the dividend.

The unit sits between operand read and register write-back. Instructions of any other class pass through it without effect, so it can be fed from a shared issue slot.

Top module: `alu_exec`

## Requirements
- R1: Opcode bits [2:0] give the class. Value 4 is the narrow (32-bit) class and value 7 is the wide (64-bit) class. An issued instruction of any other class leaves `writeEn` and `illegal` both low in the following cycle.
- R2: Opcode bit 3 chooses the second operand B. When it is 1, B is the source register. When it is 0, B is the immediate. Code 11 (move) writes B, so it shows this selection directly.
- R3: In the narrow class, the result holds the 32-bit operation on the low halves of the operands, and bits [63:32] are zero.
- R4: In the wide class, the immediate is sign-extended from bit 31 to 64 bits before use.
- R5: Opcode bits [7:4] give the operation code, with A being the destination value:
  - 0 is add.
  - 1 is A minus B.
  - 2 is multiply, keeping the low bits.
  - 3 is unsigned divide A/B.
  - 4 is OR.
  - 5 is AND.
  - 6 is shift left.
  - 7 is logical shift right.
  - 8 is negate A, with B ignored.
  - 9 is unsigned remainder A%B.
  - 10 is XOR.
  - 11 is move B.
  - 12 is arithmetic shift right.

  Examples: opcode 0x0c is a narrow register add, 0x0f is a wide register add, 0xa4 is a narrow immediate XOR and 0xa7 is a wide immediate XOR.
- R6: Shift amounts use only B[4:0] in the narrow class and only B[5:0] in the wide class.
- R7: Divide (code 3) with B equal to zero at the operation width gives a result of zero.
- R8: Remainder (code 9) with B equal to zero gives back A. In the wide class this is the unchanged destination value. In the narrow class it is the low 32 bits of the destination, zero-extended.
- R9: Codes 13, 14 and 15 in either ALU class raise `illegal` in the next cycle and keep `writeEn` low.
- R10: Each output is registered and appears one cycle after issue. While `rstN` is low, and in the cycle after a cycle with `issue` low, `writeEn` and `illegal` are low. Reset clears `result` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Operation code, class and operand select |
| dstIn | input | 64 | Current destination register value |
| srcIn | input | 64 | Source register value |
| immIn | input | 32 | Immediate operand |
| result | output | 64 | New destination value, valid when `writeEn` is high |
| writeEn | output | 1 | Write back `result` this cycle |
| illegal | output | 1 | Undefined operation code in an ALU class |

## Verification
The assertions assume the following about the inputs:
- `issue`, `opcode` and the operand inputs are stable and defined at each rising edge.
- Once `rstN` has risen, it stays high.

The single-cycle properties need the operands of the previous cycle, such as the dividend in the remainder-by-zero check, so the bench changes inputs only on the falling clock edge. This guarantees that each sampled value belongs to exactly one instruction. The bench sweeps every operation code in both classes and both operand modes over eight operand patterns. The patterns include:
- A zero low half with non-zero upper bits, which exercises the narrow divisor-zero rule.
- A negative immediate, which exercises sign extension.
- A shift amount of 37, which exercises the masking rule.

It also drives every non-ALU class value, and it drives idle cycles.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  localparam logic [2:0] CLS_NARROW = 3'h4;
  localparam logic [2:0] CLS_WIDE   = 3'h7;

  localparam logic [3:0] OP_ADD  = 4'h0;
  localparam logic [3:0] OP_SUB  = 4'h1;
  localparam logic [3:0] OP_MUL  = 4'h2;
  localparam logic [3:0] OP_DIV  = 4'h3;
  localparam logic [3:0] OP_OR   = 4'h4;
  localparam logic [3:0] OP_AND  = 4'h5;
  localparam logic [3:0] OP_SHL  = 4'h6;
  localparam logic [3:0] OP_SHR  = 4'h7;
  localparam logic [3:0] OP_NEG  = 4'h8;
  localparam logic [3:0] OP_REM  = 4'h9;
  localparam logic [3:0] OP_XOR  = 4'ha;
  localparam logic [3:0] OP_MOV  = 4'hb;
  localparam logic [3:0] OP_SAR  = 4'hc;
  localparam logic [3:0] OP_LAST = OP_SAR;

  typedef struct packed {
    logic       write;
    logic       illegal;
    logic       wide;
    logic       useReg;
    logic [3:0] op;
  } ctrlT;

endpackage

// File: rtl/alu_exec_ctrl.sv
module alu_exec_ctrl
  import alu_exec_pkg::*;
(
  input  logic       issue,
  input  logic [7:0] opcode,
  output ctrlT       ctrl
);

  logic [2:0] cls;
  logic [3:0] code;
  logic       isNarrow;
  logic       isWide;
  logic       known;
  logic       mine;

  always_comb begin
    cls      = opcode[2:0];
    code     = opcode[7:4];
    isNarrow = (cls == CLS_NARROW);
    isWide   = (cls == CLS_WIDE);
    mine     = issue && (isNarrow || isWide);
    known    = (code <= OP_LAST);

    ctrl.write   = mine && known;
    ctrl.illegal = mine && !known;
    ctrl.wide    = isWide;
    ctrl.useReg  = opcode[3];
    ctrl.op      = code;
  end

endmodule

// File: rtl/alu_exec_lane.sv
module alu_exec_lane
  import alu_exec_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  localparam int SH = $clog2(W);

  logic         bZero;
  logic [SH-1:0] amt;

  always_comb begin
    bZero = (b == '0);
    amt   = b[SH-1:0];
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = a * b;
      OP_DIV:  y = bZero ? '0 : a / b;
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      OP_SHL:  y = a << amt;
      OP_SHR:  y = a >> amt;
      OP_NEG:  y = '0 - a;
      OP_REM:  y = bZero ? a : a % b;
      OP_XOR:  y = a ^ b;
      OP_MOV:  y = b;
      OP_SAR:  y = W'($signed(a) >>> amt);
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/alu_exec_datapath.sv
module alu_exec_datapath
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctrl,
  input  logic [DATA_W-1:0] dstIn,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [DATA_W/2-1:0] immIn,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic              illegal
);

  localparam int NW = DATA_W / 2;

  logic [NW-1:0]     bNarrow;
  logic [DATA_W-1:0] bWide;
  logic [NW-1:0]     yNarrow;
  logic [DATA_W-1:0] yWide;
  logic [DATA_W-1:0] nextResult;

  always_comb begin
    bNarrow = ctrl.useReg ? srcIn[NW-1:0] : immIn;
    bWide   = ctrl.useReg ? srcIn : {{(DATA_W-NW){immIn[NW-1]}}, immIn};
  end

  alu_exec_lane #(.W(NW)) narrowLane (
    .op (ctrl.op),
    .a  (dstIn[NW-1:0]),
    .b  (bNarrow),
    .y  (yNarrow)
  );

  alu_exec_lane #(.W(DATA_W)) wideLane (
    .op (ctrl.op),
    .a  (dstIn),
    .b  (bWide),
    .y  (yWide)
  );

  always_comb begin
    nextResult = ctrl.wide ? yWide : {{(DATA_W-NW){1'b0}}, yNarrow};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result  <= '0;
      writeEn <= 1'b0;
      illegal <= 1'b0;
    end else begin
      writeEn <= ctrl.write;
      illegal <= ctrl.illegal;
      if (ctrl.write) result <= nextResult;
    end
  end

endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_exec_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issue,
  input  logic [7:0]          opcode,
  input  logic [DATA_W-1:0]   dstIn,
  input  logic [DATA_W-1:0]   srcIn,
  input  logic [DATA_W/2-1:0] immIn,
  output logic [DATA_W-1:0]   result,
  output logic                writeEn,
  output logic                illegal
);

  ctrlT ctrl;

  alu_exec_ctrl ctrlUnit (
    .issue  (issue),
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  alu_exec_datapath #(.DATA_W(DATA_W)) dataUnit (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .dstIn   (dstIn),
    .srcIn   (srcIn),
    .immIn   (immIn),
    .result  (result),
    .writeEn (writeEn),
    .illegal (illegal)
  );

endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                issue,
  input logic [7:0]          opcode,
  input logic [DATA_W-1:0]   dstIn,
  input logic [DATA_W-1:0]   srcIn,
  input logic [DATA_W/2-1:0] immIn,
  input logic [DATA_W-1:0]   result,
  input logic                writeEn,
  input logic                illegal
);

  localparam int NW = DATA_W / 2;

  logic aluCls;
  assign aluCls = (opcode[2:0] == 3'h4) || (opcode[2:0] == 3'h7);

  assert_other_class_R1: assert property (@(posedge clk) disable iff (!rstN)
    (issue && !aluCls) |=> (!writeEn && !illegal));

  assert_narrow_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (issue && opcode[2:0] == 3'h4 && opcode[7:4] <= 4'hc)
      |=> (writeEn && result[DATA_W-1:NW] == '0));

  assert_div_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (issue && opcode == 8'h3f && srcIn == '0) |=> (writeEn && result == '0));

  assert_rem_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (issue && opcode == 8'h97 && immIn == '0) |=> (writeEn && result == $past(dstIn)));

  assert_undefined_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    (issue && aluCls && opcode[7:4] > 4'hc) |=> (illegal && !writeEn));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !issue |=> (!writeEn && !illegal));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(writeEn && illegal));

endmodule

bind alu_exec alu_exec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .issue   (issue),
  .opcode  (opcode),
  .dstIn   (dstIn),
  .srcIn   (srcIn),
  .immIn   (immIn),
  .result  (result),
  .writeEn (writeEn),
  .illegal (illegal)
);

// File: tb/alu_exec_test.sv
`timescale 1ns/1ps
module alu_exec_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        issue;
  logic [7:0]  opcode;
  logic [63:0] dstIn;
  logic [63:0] srcIn;
  logic [31:0] immIn;
  logic [63:0] result;
  logic        writeEn;
  logic        illegal;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  alu_exec uut (
    .clk(clk), .rstN(rstN), .issue(issue), .opcode(opcode),
    .dstIn(dstIn), .srcIn(srcIn), .immIn(immIn),
    .result(result), .writeEn(writeEn), .illegal(illegal)
  );

  logic [63:0] pats [8];
  initial begin
    pats[0] = 64'h0;
    pats[1] = 64'h1;
    pats[2] = 64'h25;
    pats[3] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[4] = 64'h8000_0000_0000_0000;
    pats[5] = 64'h0000_0000_8000_0001;
    pats[6] = 64'h1234_5678_9ABC_DEF0;
    pats[7] = 64'h0000_0001_0000_0000;
  end

  task automatic check(input string tag, input logic [63:0] r, input logic we,
                       input logic il, input logic [63:0] er, input logic ewe,
                       input logic eil);
    compared++;
    if (we !== ewe || il !== eil || (ewe && r !== er)) begin
      mismatched++;
      $display("FAIL %s op=%02h: got res=%016h we=%0b ill=%0b exp res=%016h we=%0b ill=%0b",
               tag, opcode, r, we, il, er, ewe, eil);
    end
  endtask

  function automatic void model(input logic [7:0] opc, input logic [63:0] d,
      input logic [63:0] s, input logic [31:0] im, output logic [63:0] r,
      output logic we, output logic il, output string tag);
    logic [3:0]  code = opc[7:4];
    logic        fromReg = opc[3];
    logic [31:0] a32, b32, y32;
    logic [63:0] a64, b64, y64;
    r = 64'h0; we = 1'b0; il = 1'b0;
    if (opc[2:0] != 3'h4 && opc[2:0] != 3'h7) begin tag = "R1"; return; end
    if (code > 4'hc) begin il = 1'b1; tag = "R9"; return; end
    we = 1'b1;
    if (opc[2:0] == 3'h4) begin
      a32 = d[31:0];
      b32 = fromReg ? s[31:0] : im;
      case (code)
        4'h0: y32 = a32 + b32;
        4'h1: y32 = a32 - b32;
        4'h2: y32 = a32 * b32;
        4'h3: y32 = (b32 == 0) ? 32'h0 : a32 / b32;
        4'h4: y32 = a32 | b32;
        4'h5: y32 = a32 & b32;
        4'h6: y32 = a32 << b32[4:0];
        4'h7: y32 = a32 >> b32[4:0];
        4'h8: y32 = 32'h0 - a32;
        4'h9: y32 = (b32 == 0) ? a32 : a32 % b32;
        4'ha: y32 = a32 ^ b32;
        4'hb: y32 = b32;
        default: y32 = 32'($signed(a32) >>> b32[4:0]);
      endcase
      r = {32'h0, y32};
      if (code == 4'h3 && b32 == 0) tag = "R7";
      else if (code == 4'h9 && b32 == 0) tag = "R8";
      else if (code == 4'h6 || code == 4'h7 || code == 4'hc) tag = "R6";
      else if (code == 4'hb) tag = "R2";
      else tag = "R3";
    end else begin
      a64 = d;
      b64 = fromReg ? s : {{32{im[31]}}, im};
      case (code)
        4'h0: y64 = a64 + b64;
        4'h1: y64 = a64 - b64;
        4'h2: y64 = a64 * b64;
        4'h3: y64 = (b64 == 0) ? 64'h0 : a64 / b64;
        4'h4: y64 = a64 | b64;
        4'h5: y64 = a64 & b64;
        4'h6: y64 = a64 << b64[5:0];
        4'h7: y64 = a64 >> b64[5:0];
        4'h8: y64 = 64'h0 - a64;
        4'h9: y64 = (b64 == 0) ? a64 : a64 % b64;
        4'ha: y64 = a64 ^ b64;
        4'hb: y64 = b64;
        default: y64 = 64'($signed(a64) >>> b64[5:0]);
      endcase
      r = y64;
      if (code == 4'h3 && b64 == 0) tag = "R7";
      else if (code == 4'h9 && b64 == 0) tag = "R8";
      else if (code == 4'h6 || code == 4'h7 || code == 4'hc) tag = "R6";
      else if (code == 4'hb) tag = "R2";
      else if (!fromReg) tag = "R4";
      else tag = "R5";
    end
  endfunction

  task automatic runOne(input logic [7:0] opc, input logic [63:0] d, input logic [63:0] s);
    logic [63:0] er;
    logic ewe, eil;
    string tag;
    issue = 1'b1; opcode = opc; dstIn = d; srcIn = s; immIn = s[31:0];
    model(opc, d, s, s[31:0], er, ewe, eil, tag);
    @(negedge clk);
    check(tag, result, writeEn, illegal, er, ewe, eil);
  endtask

  initial begin
    rstN = 1'b0; issue = 1'b0; opcode = 8'h0;
    dstIn = 64'h0; srcIn = 64'h0; immIn = 32'h0;
    repeat (3) @(negedge clk);
    check("R10", result, writeEn, illegal, 64'h0, 1'b0, 1'b0);
    compared++;
    if (result !== 64'h0) begin
      mismatched++;
      $display("FAIL R10 reset result: got %016h exp 0", result);
    end
    rstN = 1'b1;
    @(negedge clk);
    check("R10", result, writeEn, illegal, 64'h0, 1'b0, 1'b0);

    runOne(8'h0c, 64'hFFFF_FFFF_0000_0005, 64'h0000_0001_FFFF_FFFF);
    runOne(8'h0f, 64'hFFFF_FFFF_0000_0005, 64'h0000_0001_FFFF_FFFF);
    runOne(8'ha4, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_8000_0000);
    runOne(8'ha7, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_8000_0000);

    for (int c = 0; c < 2; c++)
      for (int rs = 0; rs < 2; rs++)
        for (int code = 0; code < 16; code++)
          for (int di = 0; di < 8; di++)
            for (int si = 0; si < 8; si++)
              runOne({code[3:0], rs[0], (c == 0) ? 3'h4 : 3'h7}, pats[di], pats[si]);

    for (int cl = 0; cl < 8; cl++) begin
      if (cl == 4 || cl == 7) continue;
      for (int code = 0; code < 16; code += 5)
        runOne({code[3:0], 1'b1, cl[2:0]}, pats[6], pats[1]);
    end

    issue = 1'b0;
    @(negedge clk);
    check("R10", result, writeEn, illegal, 64'h0, 1'b0, 1'b0);
    @(negedge clk);
    check("R10", result, writeEn, illegal, 64'h0, 1'b0, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule